// File: doc/BRIEF.md
# Sticky Status and Interrupt Controller

This block gathers line-status events into registers that a host can read, and it drives one shared interrupt request that is active low. A vector of performance status levels is compared each clock against a registered copy. A change in either direction marks that source as pending. Two pulse inputs report elastic store overflow and underflow. Each of them sets a sticky flag that holds until the host reads the status register. Each pulse also marks its own source as pending.

The host reaches the block through a simple access port. With select 0 it reads the status register, and that read clears both sticky flags. With select 1 it reads or writes the clear/mask register. That register holds one bit per source, laid out the same way as the pending flags. A 1 in a bit clears the pending flag for that source and masks it. A 0 re-enables the source. The interrupt stays latched low until every pending and unmasked source is gone. The output stage can only pull the line low, so the block also provides an enable for a pull-down driver.

Source index layout, used by both the status register and the clear/mask register:
- Bits `[NPERF-1:0]` are the performance sources.
- Bit `NPERF` is overflow.
- Bit `NPERF+1` is underflow.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset the sticky flags, pending flags, mask bits and registered performance copy are all 0. `irq_n_o` is 1, `pd_en_o` is 0 and a status read returns 0.
- R2: A rise or a fall of `perf_i[i]` relative to its registered copy, with mask bit i at 0, drives `irq_n_o` low after the next clock edge.
- R3: An `ovf_evt_i` pulse sets status bit NPERF, and an `unf_evt_i` pulse sets status bit NPERF+1, after the next clock edge.
- R4: A status read (`acc_en_i`=1, `acc_wr_i`=0, `acc_sel_i`=0) returns the sticky flags as they stand. It clears both flags at the clock edge that ends the read.
- R5: If an overflow or underflow event arrives in the same cycle as a status read, the new event wins and its flag stays 1.
- R6: Overflow and underflow pulses are interrupt sources. With their mask bit at 0 they drive `irq_n_o` low after the next edge.
- R7: Once `irq_n_o` is low it stays low while no write to the clear/mask register occurs, even after the causing inputs return to rest.
- R8: A write (`acc_wr_i`=1, `acc_sel_i`=1) of 1 to a mask bit drops that source from the interrupt after the write edge. Later events on that source do not pull `irq_n_o` low.
- R9: Writing 0 to a mask bit re-enables the source. The next event on that source pulls `irq_n_o` low again.
- R10: `pd_en_o` is always the inverse of `irq_n_o`.
- R11: A read with `acc_sel_i`=1 returns the mask bits and has no side effect. A write with `acc_sel_i`=0 changes nothing.
- R12: Status bits `[NPERF-1:0]` return the performance levels as registered on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| perf_i | input | NPERF | Performance status levels |
| ovf_evt_i | input | 1 | Elastic store overflow pulse |
| unf_evt_i | input | 1 | Elastic store underflow pulse |
| acc_en_i | input | 1 | Register access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 1 | 0 = status register, 1 = clear/mask register |
| acc_wdata_i | input | NPERF+2 | Write data for the clear/mask register |
| acc_rdata_o | output | NPERF+2 | Read data for the selected register (combinational) |
| irq_n_o | output | 1 | Latched interrupt request, active low |
| pd_en_o | output | 1 | Enable for the pull-down driver on the shared line |

## Verification
Every stored result appears exactly one clock edge after the inputs that cause it. This covers pending flags, sticky flags, mask bits and the registered performance copy. The read data is combinational on the current registers and the select input. The bench drives its inputs 2 ns after a falling edge, so each input stays stable across the rising edge that consumes it. A behavioural model is updated at every rising edge and compared with the outputs at the following falling edge. Directed checks sample 12 ns after the consuming edge; read data is checked 1 ns after the access is driven, before that edge clears anything.

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl #(
  parameter int NPERF = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPERF-1:0] perf_i,
  input  logic             ovf_evt_i,
  input  logic             unf_evt_i,
  input  logic             acc_en_i,
  input  logic             acc_wr_i,
  input  logic             acc_sel_i,
  input  logic [NPERF+1:0] acc_wdata_i,
  output logic [NPERF+1:0] acc_rdata_o,
  output logic             irq_n_o,
  output logic             pd_en_o
);
  localparam int NSRC = NPERF + 2;

  logic [NPERF-1:0] perf_q;
  logic [NSRC-1:0]  pend, mask_q, evt;
  logic             ovf_st, unf_st, rd_stat, wr_clr;

  assign evt     = {unf_evt_i, ovf_evt_i, perf_i ^ perf_q};
  assign rd_stat = acc_en_i & ~acc_wr_i & ~acc_sel_i;
  assign wr_clr  = acc_en_i &  acc_wr_i &  acc_sel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perf_q <= '0;
      pend   <= '0;
      mask_q <= '0;
      ovf_st <= 1'b0;
      unf_st <= 1'b0;
    end else begin
      perf_q <= perf_i;
      pend   <= evt | (pend & ~mask_q);
      ovf_st <= ovf_evt_i | (ovf_st & ~rd_stat);
      unf_st <= unf_evt_i | (unf_st & ~rd_stat);
      if (wr_clr) mask_q <= acc_wdata_i;
    end
  end

  assign acc_rdata_o = acc_sel_i ? mask_q : {unf_st, ovf_st, perf_q};
  assign irq_n_o     = ~|(pend & ~mask_q);
  assign pd_en_o     = ~irq_n_o;
endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk #(
  parameter int NPERF = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPERF-1:0] perf_i,
  input logic             ovf_evt_i,
  input logic             unf_evt_i,
  input logic             acc_en_i,
  input logic             acc_wr_i,
  input logic             acc_sel_i,
  input logic [NPERF+1:0] acc_wdata_i,
  input logic             irq_n_o,
  input logic             pd_en_o,
  input logic [NPERF-1:0] perf_q,
  input logic [NPERF+1:0] mask_q,
  input logic             ovf_st,
  input logic             unf_st
);
  logic clr_wr, stat_rd;
  assign clr_wr  = acc_en_i & acc_wr_i & acc_sel_i;
  assign stat_rd = acc_en_i & ~acc_wr_i & ~acc_sel_i;

  // R10
  pulldown_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en_o == !irq_n_o);

  // R2
  perf_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|((perf_i ^ perf_q) & ~mask_q[NPERF-1:0])) && !clr_wr) |=> !irq_n_o);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_i |=> ovf_st);

  // R4
  ovf_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovf_evt_i) |=> !ovf_st);

  // R5
  unf_read_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && unf_evt_i) |=> unf_st);

  // R6
  ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_i && !mask_q[NPERF] && !clr_wr) |=> !irq_n_o);

  // R7
  irq_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !clr_wr) |=> !irq_n_o);

  // R8
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (&acc_wdata_i)) |=> irq_n_o);

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> $stable(mask_q));
endmodule

bind stat_irq_ctrl stat_irq_chk #(.NPERF(NPERF)) u_chk (
  .clk(clk), .rst_n(rst_n), .perf_i(perf_i), .ovf_evt_i(ovf_evt_i),
  .unf_evt_i(unf_evt_i), .acc_en_i(acc_en_i), .acc_wr_i(acc_wr_i),
  .acc_sel_i(acc_sel_i), .acc_wdata_i(acc_wdata_i), .irq_n_o(irq_n_o),
  .pd_en_o(pd_en_o), .perf_q(perf_q), .mask_q(mask_q), .ovf_st(ovf_st),
  .unf_st(unf_st));

// File: tb/tb_stat_irq_ctrl.sv
module tb_stat_irq_ctrl;
  localparam int NPERF = 6;
  localparam int NSRC  = NPERF + 2;

  logic clk = 0, rst_n = 0;
  logic [NPERF-1:0] perf_i = '0;
  logic ovf_evt_i = 0, unf_evt_i = 0, acc_en_i = 0, acc_wr_i = 0, acc_sel_i = 0;
  logic [NSRC-1:0] acc_wdata_i = '0;
  logic [NSRC-1:0] acc_rdata_o;
  logic irq_n_o, pd_en_o;

  int checks = 0, fails = 0;
  bit done = 0;

  stat_irq_ctrl #(.NPERF(NPERF)) dut (
    .clk(clk), .rst_n(rst_n), .perf_i(perf_i), .ovf_evt_i(ovf_evt_i),
    .unf_evt_i(unf_evt_i), .acc_en_i(acc_en_i), .acc_wr_i(acc_wr_i),
    .acc_sel_i(acc_sel_i), .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o),
    .irq_n_o(irq_n_o), .pd_en_o(pd_en_o));

  always #10 clk = ~clk;

  bit m_perf [NPERF];
  bit m_pend [NSRC];
  bit m_mask [NSRC];
  bit m_ovf, m_unf;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_irq_n();
    for (int i = 0; i < NSRC; i++) if (m_pend[i] && !m_mask[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [NSRC-1:0] exp_rdata();
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++) begin
      if (acc_sel_i) v[i] = m_mask[i];
      else if (i < NPERF) v[i] = m_perf[i];
      else if (i == NPERF) v[i] = m_ovf;
      else v[i] = m_unf;
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin m_pend[i] = 0; m_mask[i] = 0; end
      for (int i = 0; i < NPERF; i++) m_perf[i] = 0;
      m_ovf = 0; m_unf = 0;
    end else begin
      bit rd, e;
      rd = acc_en_i && !acc_wr_i && !acc_sel_i;
      for (int i = 0; i < NSRC; i++) begin
        if (i < NPERF) e = (perf_i[i] != m_perf[i]);
        else if (i == NPERF) e = ovf_evt_i;
        else e = unf_evt_i;
        m_pend[i] = e || (m_pend[i] && !m_mask[i]);
      end
      m_ovf = ovf_evt_i || (m_ovf && !rd);
      m_unf = unf_evt_i || (m_unf && !rd);
      if (acc_en_i && acc_wr_i && acc_sel_i)
        for (int i = 0; i < NSRC; i++) m_mask[i] = acc_wdata_i[i];
      for (int i = 0; i < NPERF; i++) m_perf[i] = perf_i[i];
    end
  end

  // per-cycle comparison: R2/R6/R7/R8/R9 on irq, R10 on pd_en, R3/R4/R11/R12 on read data
  always @(negedge clk) if (rst_n && !done) begin
    check(irq_n_o === exp_irq_n(), "R2/R6/R7/R8/R9 irq_n", irq_n_o, exp_irq_n());
    check(pd_en_o === !exp_irq_n(), "R10 pd_en", pd_en_o, !exp_irq_n());
    check(acc_rdata_o === exp_rdata(), "R3/R4/R11/R12 rdata", acc_rdata_o, exp_rdata());
  end

  task automatic idle();
    ovf_evt_i = 0; unf_evt_i = 0; acc_en_i = 0; acc_wr_i = 0; acc_sel_i = 0;
  endtask

  task automatic tick();
    @(posedge clk); #12;
    idle();
  endtask

  task automatic wr_mask(input logic [NSRC-1:0] d);
    acc_en_i = 1; acc_wr_i = 1; acc_sel_i = 1; acc_wdata_i = d;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #12 rst_n = 1;
    #1;
    check(irq_n_o === 1 && pd_en_o === 0, "R1 reset irq", {irq_n_o, pd_en_o}, 2'b10);
    check(acc_rdata_o === '0, "R1 reset status", acc_rdata_o, 0);
    tick();

    perf_i[2] = 1; tick();
    check(irq_n_o === 0, "R2 rising change", irq_n_o, 0);
    check(acc_rdata_o[2] === 1, "R12 registered level", acc_rdata_o[2], 1);
    repeat (3) tick();
    check(irq_n_o === 0, "R7 latched low", irq_n_o, 0);

    wr_mask('1);
    check(irq_n_o === 1, "R8 release after mask", irq_n_o, 1);
    wr_mask('0);
    check(irq_n_o === 1, "R9 no stale irq", irq_n_o, 1);
    perf_i[2] = 0; tick();
    check(irq_n_o === 0, "R2 falling change", irq_n_o, 0);

    wr_mask(NSRC'(1) << 2); tick();
    check(irq_n_o === 1, "R8 cleared", irq_n_o, 1);
    perf_i[2] = 1; tick();
    check(irq_n_o === 1, "R8 masked source silent", irq_n_o, 1);
    perf_i[3] = 1; tick();
    check(irq_n_o === 0, "R2 unmasked source", irq_n_o, 0);
    wr_mask('1); wr_mask('0);

    ovf_evt_i = 1; tick();
    check(acc_rdata_o[NPERF] === 1, "R3 overflow sticky", acc_rdata_o[NPERF], 1);
    check(irq_n_o === 0, "R6 overflow irq", irq_n_o, 0);
    repeat (2) tick();
    acc_en_i = 1; #1;
    check(acc_rdata_o[NPERF] === 1, "R4 read shows flag", acc_rdata_o[NPERF], 1);
    tick();
    check(acc_rdata_o[NPERF] === 0, "R4 cleared by read", acc_rdata_o[NPERF], 0);

    unf_evt_i = 1; tick();
    check(acc_rdata_o[NPERF+1] === 1, "R3 underflow sticky", acc_rdata_o[NPERF+1], 1);
    acc_en_i = 1; unf_evt_i = 1; ovf_evt_i = 1; tick();
    check(acc_rdata_o[NPERF+1:NPERF] === 2'b11, "R5 event beats read",
          acc_rdata_o[NPERF+1:NPERF], 2'b11);

    wr_mask(NSRC'(1) << NPERF);
    acc_en_i = 1; acc_wr_i = 1; acc_sel_i = 0; acc_wdata_i = '0; tick();
    acc_sel_i = 1; #1;
    check(acc_rdata_o === (NSRC'(1) << NPERF), "R11 status write ignored",
          acc_rdata_o, NSRC'(1) << NPERF);
    acc_en_i = 1; acc_sel_i = 1; tick();
    acc_sel_i = 1; #1;
    check(acc_rdata_o === (NSRC'(1) << NPERF), "R11 mask read no side effect",
          acc_rdata_o, NSRC'(1) << NPERF);
    ovf_evt_i = 1; tick();
    ovf_evt_i = 0; wr_mask('1); wr_mask('0);
    check(irq_n_o === 1, "R6 masked overflow dropped", irq_n_o, 1);
    ovf_evt_i = 1; tick();
    check(irq_n_o === 0, "R9 overflow re-enabled", irq_n_o, 0);

    void'($urandom(7));
    for (int n = 0; n < 2000; n++) begin
      if ($urandom % 6 == 0) perf_i[$urandom % NPERF] ^= 1'b1;
      ovf_evt_i = ($urandom % 10 == 0);
      unf_evt_i = ($urandom % 10 == 0);
      if ($urandom % 4 == 0) begin
        acc_en_i = 1; acc_wr_i = $urandom; acc_sel_i = $urandom;
        acc_wdata_i = NSRC'($urandom);
      end
      @(posedge clk); #12;
      idle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule